// File: doc/BRIEF.md
# Strobe Watchdog with Post-Reset Long Timeout

This block checks that a processor is still running by watching an activity strobe. Each change of the strobe level, rising or falling, restarts a counter that advances on timebase ticks. When the counter reaches its limit, the block emits a one-clock timeout pulse, which a reset generator uses to start a reset. It also drives an active-low fault flag low and latches it there. A separate disable flag marks the strobe as floating or mid-level. While that flag is set, the watchdog is switched off.

There are two timeout lengths. After any reset the limit is the long one. This gives start-up software time to initialise before it must service the strobe. The first strobe change after the reset ends arms the short, normal limit. A period-select input can hold the long limit in every state. The reset generator reports its reset interval on a busy input. Counting is frozen and cleared during that interval, so a fresh period always starts when the reset ends. A supply-low indication forces the fault flag back to its inactive level.

Top module: `strobe_watchdog`

## Requirements
- R1: A change of the synchronized strobe level in either direction restarts the count from zero. The strobe passes two synchronizer flops, so a change driven on `strobe_lvl_i` takes effect at the third rising clock edge.
- R2: While `strobe_float_i` is 1 (after synchronization), no timeout occurs, the count is held at zero, and strobe level changes are ignored: they neither clear the fault flag nor arm the short limit.
- R3: In the armed short state with `long_sel_i` = 0, the timeout occurs on exactly the `SHORT_TICKS`-th tick after a restart.
- R4: After power-on reset (`rst_n` low) and after every `rst_busy_i` interval, the limit is `LONG_TICKS`. The short limit is armed only by the first strobe change seen while `rst_busy_i` is 0. A change seen while `rst_busy_i` is 1 does not arm it.
- R5: With `long_sel_i` = 1, the limit is `LONG_TICKS` even in the armed state.
- R6: While `rst_busy_i` is 1, ticks are not counted and no timeout occurs. When `rst_busy_i` returns to 0, the count starts again from zero.
- R7: A timeout drives `timeout_o` high for exactly one clock and drives `fault_n_o` to 0 in the same cycle. `fault_n_o` stays 0 until the next accepted strobe change.
- R8: `supply_low_i` = 1 forces `fault_n_o` to 1 on the next clock. This overrides a timeout that falls in the same cycle.
- R9: If the strobe never changes and each timeout is followed by a `rst_busy_i` interval, consecutive timeouts are `LONG_TICKS` ticks apart.
- R10: A strobe change that reaches the counter in the same cycle as the terminal tick takes priority. No timeout occurs, and a full period starts again.
- R11: Out of reset, `timeout_o` is 0 and `fault_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_lvl_i | input | 1 | Asynchronous strobe level from the processor |
| strobe_float_i | input | 1 | Asynchronous flag, 1 = strobe floating/mid-level (watchdog off) |
| tick_i | input | 1 | Timebase tick, one clock wide |
| long_sel_i | input | 1 | 1 = always use the long limit |
| rst_busy_i | input | 1 | 1 while the reset generator holds reset |
| supply_low_i | input | 1 | 1 while the supply is below its threshold |
| timeout_o | output | 1 | One-clock timeout pulse to the reset generator |
| fault_n_o | output | 1 | Latched watchdog fault, active low |

## Verification
Two events can fall in the same cycle: the terminal tick that ends a period, and a strobe change that restarts it. To provoke this, the bench flips the strobe exactly two clocks before it raises the terminal tick. It then requires no timeout pulse, a fault flag that stays high, and a full short period before the next timeout. A second collision, a timeout and supply-low in the same cycle, is also provoked. In that case the bench requires the timeout pulse to appear while the fault flag stays high.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic {
    PER_SHORT = 1'b0,
    PER_LONG  = 1'b1
  } per_mode_e;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] st1_q, st2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_q <= '0;
      st2_q <= '0;
    end else begin
      st1_q <= d_i;
      st2_q <= st1_q;
    end
  end

  assign q_o = st2_q;

endmodule

// File: rtl/wdt_edge.sv
module wdt_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic dis_i,
  output logic edge_o
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  // both polarities count; a disabled input produces no edges
  assign edge_o = (lvl_i ^ prev_q) & ~dis_i;

endmodule

// File: rtl/wdt_period_ctr.sv
module wdt_period_ctr #(
  parameter int unsigned SHORT_TICKS = 1024,
  parameter int unsigned LONG_TICKS  = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic busy_i,
  input  logic dis_i,
  input  logic restart_i,
  input  logic long_sel_i,
  output logic fire_o
);
  import wdt_pkg::*;

  localparam int unsigned CW = cnt_width(LONG_TICKS);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_TICKS - 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_TICKS - 1);

  logic [CW-1:0] cnt_q, cnt_d, last_s;
  per_mode_e     mode_q, mode_d;
  logic          cnt_en, mode_en;

  always_comb begin
    last_s  = (long_sel_i || (mode_q == PER_LONG)) ? LONG_LAST : SHORT_LAST;
    cnt_d   = cnt_q;
    mode_d  = mode_q;
    fire_o  = 1'b0;
    if (busy_i) begin
      cnt_d  = '0;
      mode_d = PER_LONG;
    end else if (dis_i) begin
      cnt_d  = '0;
    end else if (restart_i) begin
      cnt_d  = '0;
      mode_d = PER_SHORT;
    end else if (tick_i) begin
      if (cnt_q == last_s) begin
        cnt_d  = '0;
        fire_o = 1'b1;
      end else begin
        cnt_d  = cnt_q + CW'(1);
      end
    end
    cnt_en  = (cnt_d != cnt_q);
    mode_en = (mode_d != mode_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= PER_LONG;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

endmodule

// File: rtl/wdt_fault_out.sv
module wdt_fault_out (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  input  logic restart_i,
  input  logic supply_low_i,
  output logic timeout_o,
  output logic fault_n_o
);

  logic pulse_q, pulse_d;
  logic fault_q, fault_d;

  always_comb begin
    pulse_d = fire_i;
    fault_d = fault_q;
    if (supply_low_i)   fault_d = 1'b1;
    else if (fire_i)    fault_d = 1'b0;
    else if (restart_i) fault_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      fault_q <= 1'b1;
    end else begin
      pulse_q <= pulse_d;
      fault_q <= fault_d;
    end
  end

  assign timeout_o = pulse_q;
  assign fault_n_o = fault_q;

endmodule

// File: rtl/strobe_watchdog.sv
module strobe_watchdog #(
  parameter int unsigned SHORT_TICKS = 1024,
  parameter int unsigned LONG_TICKS  = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_lvl_i,
  input  logic strobe_float_i,
  input  logic tick_i,
  input  logic long_sel_i,
  input  logic rst_busy_i,
  input  logic supply_low_i,
  output logic timeout_o,
  output logic fault_n_o
);

  logic [1:0] raw_vec, sync_vec;
  logic       lvl_s, flt_s, edge_s, fire_s;

  assign raw_vec = {strobe_float_i, strobe_lvl_i};

  wdt_sync #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_vec),
    .q_o   (sync_vec)
  );

  assign lvl_s = sync_vec[0];
  assign flt_s = sync_vec[1];

  wdt_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (lvl_s),
    .dis_i  (flt_s),
    .edge_o (edge_s)
  );

  wdt_period_ctr #(
    .SHORT_TICKS (SHORT_TICKS),
    .LONG_TICKS  (LONG_TICKS)
  ) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .busy_i     (rst_busy_i),
    .dis_i      (flt_s),
    .restart_i  (edge_s),
    .long_sel_i (long_sel_i),
    .fire_o     (fire_s)
  );

  wdt_fault_out u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .fire_i       (fire_s),
    .restart_i    (edge_s),
    .supply_low_i (supply_low_i),
    .timeout_o    (timeout_o),
    .fault_n_o    (fault_n_o)
  );

endmodule

// File: rtl/strobe_watchdog_chk.sv
module strobe_watchdog_chk (
  input logic clk,
  input logic rst_n,
  input logic flt_s,
  input logic edge_s,
  input logic rst_busy_i,
  input logic supply_low_i,
  input logic timeout_o,
  input logic fault_n_o
);

  // R7
  pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o);

  // R7
  fault_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_o && !$past(supply_low_i)) |-> !fault_n_o);

  // R7
  fault_release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_n_o) |-> $past(edge_s || supply_low_i));

  // R2
  disabled_no_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flt_s |=> !timeout_o);

  // R6
  busy_no_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_busy_i |=> !timeout_o);

  // R8
  supply_forces_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low_i |=> fault_n_o);

  // R10
  edge_beats_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_s |=> !timeout_o);

endmodule

bind strobe_watchdog strobe_watchdog_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .flt_s        (flt_s),
  .edge_s       (edge_s),
  .rst_busy_i   (rst_busy_i),
  .supply_low_i (supply_low_i),
  .timeout_o    (timeout_o),
  .fault_n_o    (fault_n_o)
);

// File: tb/strobe_watchdog_tb_top.sv
`timescale 1ns/1ps
module strobe_watchdog_tb_top;

  localparam int unsigned SHORT_T = 8;
  localparam int unsigned LONG_T  = 32;

  logic clk = 1'b0;
  logic rst_n, strobe_lvl, strobe_float, tick, long_sel, rst_busy, supply_low;
  logic timeout, fault_n;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  strobe_watchdog #(.SHORT_TICKS(SHORT_T), .LONG_TICKS(LONG_T)) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .strobe_lvl_i   (strobe_lvl),
    .strobe_float_i (strobe_float),
    .tick_i         (tick),
    .long_sel_i     (long_sel),
    .rst_busy_i     (rst_busy),
    .supply_low_i   (supply_low),
    .timeout_o      (timeout),
    .fault_n_o      (fault_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one tick consumed at the next posedge; outputs sampled at the negedge after it
  task automatic do_tick(output logic to, output logic fn);
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    to = timeout;
    fn = fault_n;
  endtask

  task automatic run_ticks(input int n, input int fire_at, input string req);
    logic to, fn;
    for (int i = 1; i <= n; i++) begin
      do_tick(to, fn);
      chk(req, to, (i == fire_at) ? 1 : 0);
    end
  endtask

  // flip strobe; change reaches the counter at the third posedge
  task automatic toggle();
    @(negedge clk) strobe_lvl = ~strobe_lvl;
    repeat (3) @(negedge clk);
  endtask

  task automatic busy_pulse();
    @(negedge clk) rst_busy = 1'b1;
    repeat (4) @(negedge clk);
    rst_busy = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic to, fn;
    rst_n = 1'b0; strobe_lvl = 1'b0; strobe_float = 1'b0; tick = 1'b0;
    long_sel = 1'b0; rst_busy = 1'b0; supply_low = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 timeout", timeout, 0);
    chk("R11 fault_n", fault_n, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 timeout", timeout, 0);
    chk("R11 fault_n", fault_n, 1);

    // R4: post power-on the limit is long
    run_ticks(LONG_T, LONG_T, "R4 power-on long");
    chk("R7 fault low", fault_n, 0);
    @(negedge clk);
    chk("R7 single pulse", timeout, 0);
    chk("R7 fault held", fault_n, 0);

    // R9: repeated timeouts with reset intervals, no strobe activity
    for (int k = 0; k < 2; k++) begin
      busy_pulse();
      chk("R9 fault still low", fault_n, 0);
      run_ticks(LONG_T, LONG_T, "R9 repeat long");
    end

    // R3 / R7: edges of both polarities arm short and clear the fault
    for (int k = 0; k < 4; k++) begin
      toggle();
      chk("R7 edge clears fault", fault_n, 1);
      run_ticks(SHORT_T, SHORT_T, "R3 short period");
    end

    // R1: restart at every partial count
    for (int k = 1; k < SHORT_T; k++) begin
      toggle();
      run_ticks(k, 0, "R1 before restart");
      toggle();
      run_ticks(SHORT_T, SHORT_T, "R1 after restart");
    end

    // R10: edge arrives in the same cycle as the terminal tick
    toggle();
    run_ticks(SHORT_T - 1, 0, "R10 lead-in");
    @(negedge clk) strobe_lvl = ~strobe_lvl;
    @(negedge clk);
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    chk("R10 no timeout", timeout, 0);
    chk("R10 fault high", fault_n, 1);
    run_ticks(SHORT_T, SHORT_T, "R10 full period after");

    // R5: long select overrides armed short
    toggle();
    long_sel = 1'b1;
    run_ticks(LONG_T, LONG_T, "R5 long select");
    long_sel = 1'b0;
    toggle();
    run_ticks(SHORT_T, SHORT_T, "R5 short restored");

    // R2: disable flag
    strobe_float = 1'b1;
    repeat (3) @(negedge clk);
    toggle();
    chk("R2 ignored edge keeps fault", fault_n, 0);
    toggle();
    run_ticks(3 * LONG_T, 0, "R2 disabled");
    chk("R2 fault unchanged", fault_n, 0);
    strobe_float = 1'b0;
    repeat (3) @(negedge clk);
    run_ticks(SHORT_T, SHORT_T, "R2 count held at zero");

    // R6: busy freezes counting, restarts from zero, re-enters long
    toggle();
    run_ticks(5, 0, "R6 partial");
    @(negedge clk) rst_busy = 1'b1;
    run_ticks(2 * LONG_T, 0, "R6 no count while busy");
    rst_busy = 1'b0;
    run_ticks(LONG_T, LONG_T, "R6 restart long");
    toggle();
    run_ticks(SHORT_T, SHORT_T, "R4 armed after busy");

    // R4: edge during busy does not arm
    @(negedge clk) rst_busy = 1'b1;
    toggle();
    rst_busy = 1'b0;
    @(negedge clk);
    run_ticks(LONG_T, LONG_T, "R4 busy edge no arm");

    // R8: supply low forces fault high
    @(negedge clk) supply_low = 1'b1;
    @(negedge clk) supply_low = 1'b0;
    chk("R8 forced high", fault_n, 1);
    toggle();
    run_ticks(SHORT_T - 1, 0, "R8 lead-in");
    @(negedge clk) begin tick = 1'b1; supply_low = 1'b1; end
    @(negedge clk) begin tick = 1'b0; supply_low = 1'b0; end
    to = timeout; fn = fault_n;
    chk("R8 pulse with supply low", to, 1);
    chk("R8 overrides timeout", fn, 1);
    @(negedge clk);
    chk("R8 stays high", fault_n, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule